// File: doc/BRIEF.md
# Dual-Channel Offset Calibration Averager

This block removes a static offset from two 10-bit converter code streams. When software or a control sequencer raises the calibration request, the block opens a fixed 34-cycle window. Both analog inputs are assumed to be held at zero differential during that window, so every ideal code in it is mid-scale (512). The first two cycles of the window are thrown away so that the converter pipeline can flush. The next 32 codes of each channel are summed, averaged with rounding, and compared against mid-scale. The signed difference is stored as that channel's offset.

From the cycle after the window onward, every raw code has its channel's stored offset subtracted. The result is clamped to the legal code range and registered. The two channels share the window timing but each has its own sum and its own stored offset. Until the first calibration completes, the stored offsets are zero and codes pass through unchanged.

Top module: `offset_cal_engine`

## Requirements
- R1: A window starts only on a 0-to-1 transition of `cal_req` sampled at a clock edge; holding `cal_req` high after a window ends does not start another.
- R2: `cal_busy` rises at the output one cycle after the edge that samples the request transition and stays high for exactly 34 cycles.
- R3: Request transitions that arrive while `cal_busy` is high are ignored; the running window is neither restarted nor stretched.
- R4: The codes sampled in the first two cycles of the window are discarded; the codes sampled in the remaining 32 cycles (window positions 2 to 33) are summed per channel.
- R5: The stored offset is (sum + 16) / 32 (integer division, so halves round up) minus 512, held as a signed value in the range -512 to 511.
- R6: Each corrected output equals its raw input minus that channel's stored offset, clamped to 0 when negative and to 1023 when above 1023, and appears one clock after the raw code is sampled.
- R7: A new offset applies only to codes sampled after the last window position; codes sampled during the window, including the last one, use the previous offset.
- R8: The two channels calibrate independently: each channel's offset depends only on its own codes.
- R9: Reset clears both stored offsets to zero, drives both corrected outputs to 0 and `cal_busy` low; afterwards codes pass through unchanged until a calibration completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cal_req | input | 1 | Calibration request, acted on at its rising transition |
| raw_a | input | 10 | Raw code, channel A |
| raw_b | input | 10 | Raw code, channel B |
| corr_a | output | 10 | Corrected code, channel A |
| corr_b | output | 10 | Corrected code, channel B |
| cal_busy | output | 1 | High during the calibration window |

## Verification
The bench fills the two flush slots with full-scale codes. A design that sums from the wrong position ends with an offset far from the intended one. Alternating codes that differ by one make the average land exactly on a half, and a design that truncates stores an offset one below the rounded value. The bench drops and re-raises the request in the middle of a window and then holds it high past the end. A design that restarts on a busy edge, or that treats the request as a level, keeps `cal_busy` high beyond 34 cycles. Corrected codes are checked at both clamp limits and on the last window sample, so a wrapping subtraction or an offset applied one cycle early shows up as a wrong output code.

// File: rtl/ofs_cal_pkg.sv
package ofs_cal_pkg;
  localparam int CODE_W     = 10;
  localparam int AVG_SHIFT  = 5;
  localparam int N_SAMPLES  = 1 << AVG_SHIFT;
  localparam int SUM_W      = CODE_W + AVG_SHIFT;
  localparam int CODE_MAX   = (1 << CODE_W) - 1;
  localparam int CODE_MID   = 1 << (CODE_W - 1);

  typedef logic [CODE_W-1:0]        code_t;
  typedef logic [SUM_W-1:0]         sum_t;
  typedef logic signed [CODE_W:0]   ofs_t;

  // Rounded mean of the sum, expressed relative to mid-scale.
  function automatic ofs_t sum_to_offset(input sum_t sum);
    logic [SUM_W:0]   rounded;
    logic [CODE_W:0]  mean;
    rounded = {1'b0, sum} + (SUM_W+1)'(1 << (AVG_SHIFT - 1));
    mean    = rounded[SUM_W:AVG_SHIFT];
    return $signed(mean) - ofs_t'(CODE_MID);
  endfunction

  // Subtract the offset and clamp into the legal code range.
  function automatic code_t apply_offset(input code_t raw, input ofs_t ofs);
    logic signed [CODE_W+1:0] diff;
    diff = $signed({2'b00, raw}) - {ofs[CODE_W], ofs};
    if (diff < 0)
      return '0;
    else if (diff > (CODE_W+2)'(CODE_MAX))
      return code_t'(CODE_MAX);
    else
      return diff[CODE_W-1:0];
  endfunction
endpackage

// File: rtl/ofs_cal_seq.sv
module ofs_cal_seq #(
  parameter int SETTLE_CYC = 2,
  parameter int SAMPLE_CYC = ofs_cal_pkg::N_SAMPLES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cal_req,
  output logic busy,
  output logic acc_clr,
  output logic acc_en,
  output logic win_last
);
  localparam int WIN   = SETTLE_CYC + SAMPLE_CYC;
  localparam int CNT_W = $clog2(WIN);

  logic             req_q;
  logic [CNT_W-1:0] pos;
  logic             req_rise;

  assign req_rise = cal_req & ~req_q;
  assign acc_clr  = req_rise & ~busy;
  assign acc_en   = busy && (pos >= CNT_W'(SETTLE_CYC));
  assign win_last = busy && (pos == CNT_W'(WIN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      busy  <= 1'b0;
      pos   <= '0;
    end else begin
      req_q <= cal_req;
      if (acc_clr) begin
        busy <= 1'b1;
        pos  <= '0;
      end else if (win_last) begin
        busy <= 1'b0;
        pos  <= '0;
      end else if (busy) begin
        pos <= pos + 1'b1;
      end
    end
  end

  assert_start_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cal_req) && !$past(req_q));

  assert_start_pos_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clr |=> busy && (pos == '0));

  assert_window_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    win_last |=> !busy);

  assert_no_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !win_last) |=> busy && (pos == $past(pos) + 1'b1));
endmodule

// File: rtl/ofs_cal_chan.sv
module ofs_cal_chan
  import ofs_cal_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  code_t raw,
  input  logic  acc_clr,
  input  logic  acc_en,
  input  logic  win_last,
  output code_t corr
);
  sum_t acc;
  sum_t acc_next;
  ofs_t ofs;

  assign acc_next = acc + sum_t'(raw);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc  <= '0;
      ofs  <= '0;
      corr <= '0;
    end else begin
      if (acc_clr)
        acc <= '0;
      else if (acc_en)
        acc <= acc_next;
      if (win_last)
        ofs <= sum_to_offset(acc_next);
      corr <= apply_offset(raw, ofs);
    end
  end

  assert_acc_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_en && !acc_clr) |=> $stable(acc));

  assert_ofs_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !win_last |=> $stable(ofs));

  assert_pass_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ofs == '0) |=> corr == $past(raw));
endmodule

// File: rtl/offset_cal_engine.sv
module offset_cal_engine
  import ofs_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cal_req,
  input  logic [9:0] raw_a,
  input  logic [9:0] raw_b,
  output logic [9:0] corr_a,
  output logic [9:0] corr_b,
  output logic       cal_busy
);
  localparam int N_CH = 2;

  logic acc_clr;
  logic acc_en;
  logic win_last;
  code_t raw_v  [N_CH];
  code_t corr_v [N_CH];

  assign raw_v[0] = raw_a;
  assign raw_v[1] = raw_b;
  assign corr_a   = corr_v[0];
  assign corr_b   = corr_v[1];

  ofs_cal_seq #(
    .SETTLE_CYC(2),
    .SAMPLE_CYC(N_SAMPLES)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .cal_req  (cal_req),
    .busy     (cal_busy),
    .acc_clr  (acc_clr),
    .acc_en   (acc_en),
    .win_last (win_last)
  );

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    ofs_cal_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw      (raw_v[ch]),
      .acc_clr  (acc_clr),
      .acc_en   (acc_en),
      .win_last (win_last),
      .corr     (corr_v[ch])
    );
  end

  assert_busy_quiet_R9: assert property (@(posedge clk)
    !rst_n |=> !cal_busy && corr_a == '0 && corr_b == '0);
endmodule

// File: tb/sim_offset_cal_engine.sv
module sim_offset_cal_engine;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cal_req = 1'b0;
  logic [9:0] raw_a = '0;
  logic [9:0] raw_b = '0;
  logic [9:0] corr_a;
  logic [9:0] corr_b;
  logic       cal_busy;

  always #2.5 clk = ~clk;

  offset_cal_engine u0 (
    .clk(clk), .rst_n(rst_n), .cal_req(cal_req),
    .raw_a(raw_a), .raw_b(raw_b),
    .corr_a(corr_a), .corr_b(corr_b), .cal_busy(cal_busy)
  );

  typedef struct {
    int    ea;
    int    eb;
    bit    ebusy;
    string tag;
  } item_t;

  item_t q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // Independent behavioural model state
  int m_off[2];
  int m_sum[2];
  bit m_active;
  int m_pos;
  bit m_req_prev;

  function automatic int clamp_code(int v);
    if (v < 0) return 0;
    if (v > 1023) return 1023;
    return v;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_off[0] = 0; m_off[1] = 0;
    m_sum[0] = 0; m_sum[1] = 0;
    m_active = 0; m_pos = 0; m_req_prev = 0;
  endtask

  task automatic drive(int a, int b, bit req, string tag);
    item_t it;
    @(negedge clk);
    raw_a = 10'(a); raw_b = 10'(b); cal_req = req;
    it.ea  = clamp_code(a - m_off[0]);
    it.eb  = clamp_code(b - m_off[1]);
    it.tag = tag;
    if (m_active) begin
      if (m_pos >= 2) begin
        m_sum[0] += a;
        m_sum[1] += b;
      end
      if (m_pos == 33) begin
        m_off[0] = (m_sum[0] + 16) / 32 - 512;
        m_off[1] = (m_sum[1] + 16) / 32 - 512;
        m_active = 0;
      end else begin
        m_pos++;
      end
    end else if (req && !m_req_prev) begin
      m_active = 1; m_pos = 0;
      m_sum[0] = 0; m_sum[1] = 0;
    end
    m_req_prev = req;
    it.ebusy = m_active;
    q.push_back(it);
  endtask

  // Monitor: one result per pushed item, read just after the edge.
  always begin
    @(posedge clk);
    #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check(it.tag, "cal_busy", int'(cal_busy), int'(it.ebusy));
      check(it.tag, "corr_a", int'(corr_a), it.ea);
      check(it.tag, "corr_b R8", int'(corr_b), it.eb);
    end
  end

  // One calibration window of 35 drives: k=0 carries the edge,
  // k=1..2 are flush slots, k=3..34 are the summed samples.
  task automatic run_cal(int a_base, int a_flush, int a_alt,
                         int b_base, int b_flush, int b_alt,
                         bit poke, bit hold_after);
    for (int k = 0; k < 35; k++) begin
      int  av, bv;
      bit  rq;
      av = (k < 3) ? a_flush : a_base + ((k % 2 == 1) ? a_alt : 0);
      bv = (k < 3) ? b_flush : b_base + ((k % 2 == 1) ? b_alt : 0);
      if (poke)
        rq = (k == 10) ? 1'b0 : 1'b1;
      else
        rq = (k <= 2) || hold_after;
      drive(av, bv, rq, (k < 34) ? "R2 R4 R3" : "R7 last sample old offset");
    end
  endtask

  initial begin
    model_reset();
    raw_a = 10'd300; raw_b = 10'd700;
    repeat (3) @(posedge clk);
    #1;
    check("R9", "reset cal_busy", int'(cal_busy), 0);
    check("R9", "reset corr_a", int'(corr_a), 0);
    check("R9", "reset corr_b", int'(corr_b), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R9: pass-through before any calibration
    drive(123, 999, 0, "R9 pass");
    drive(0, 1023, 0, "R9 pass");
    drive(512, 1, 0, "R9 pass");

    // R5: centred inputs give zero offset
    run_cal(512, 512, 0, 512, 512, 0, 0, 0);
    drive(77, 1000, 0, "R5 zero offset");

    // R4: flush slots at full scale must not count; R5 rounding of halves
    run_cal(520, 1023, 0, 500, 1023, 1, 0, 1);
    drive(600, 600, 1, "R1 held high no restart R5");
    drive(600, 600, 1, "R1 held high no restart");
    drive(3, 1020, 1, "R6 clamp low A clamp high B");
    drive(8, 489, 1, "R6 exact zero and R8");
    drive(1023, 0, 0, "R6 R8");
    drive(530, 300, 0, "R6");

    // R3: request dropped and re-raised mid-window is ignored
    run_cal(512, 0, 0, 480, 0, 0, 1, 0);
    drive(512, 480, 0, "R3 R8 new offsets");
    drive(0, 1023, 0, "R6 clamp after R3");
    drive(10, 10, 0, "R6");

    // R1: a fresh edge after the request was low starts a new window
    run_cal(505, 200, 0, 512, 900, 0, 0, 0);
    drive(505, 512, 0, "R1 recal");
    drive(1020, 1023, 0, "R6 R1");
    drive(2, 0, 0, "R6 R1");

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule